// File: doc/BRIEF.md
# Sine Frame Symmetry Analyzer

This block gathers a fixed-length frame of unsigned ADC samples from a signal that should be a clean sinusoid. Once the frame is complete, it analyses the stored samples. It reports the following for each frame:

- the frame maximum and minimum;
- a frequency estimate in hertz;
- a single symmetry figure.

The symmetry figure combines two kinds of imbalance. The first is amplitude imbalance: the peaks are measured about the frame mean. The second is timing imbalance: the two half-cycle durations are compared. An ideal sine gives a figure at or near zero. A clipped or skewed waveform gives a large figure.

A frame spans a fixed time window of 50 samples at 500 kS/s, which is 100 µs. Because the window is fixed, the frequency is simply the count of positive peaks times 10000 Hz, and no divider is needed. The mean is computed with a constant-reciprocal multiply.

Analysis takes one cycle for the mean, then one cycle per interior sample, then one cycle to form the outputs. This is well inside the 200-cycle budget that applies at 50 MHz. Samples that arrive while a frame is being analysed are dropped.

Top module: `sine_symmetry_analyzer`

## Requirements
- R1: After reset, `freq_hz`, `max_val`, `min_val` and `sym_val` are 0 and `done` is low.
- R2: The block accepts `FRAME_LEN` (50) valid samples into a frame. After the last sample it pulses `done` high for exactly one cycle, no more than 200 cycles later. The outputs then hold their values until the next `done`.
- R3: `max_val` and `min_val` equal the largest and smallest samples of the frame.
- R4: The baseline is the frame mean rounded down: floor(sum of samples / 50).
- R5: An interior sample (index 1..48) is a positive peak when all of the following hold: it is ≥ the sample before it, it is > the sample after it, and it is > the baseline. A negative peak is the mirror: ≤ the sample before, < the sample after, and < the baseline. Index 0 and index 49 are never peaks.
- R6: `freq_hz` is the number of positive peaks × 10000, saturated at 65535. It is 0 when the frame has no positive peak or no negative peak.
- R7: T1 is measured from the most recent positive peak to the first negative peak that follows any positive peak. T2 is measured from the most recent negative peak to the first positive peak that follows any negative peak. Both are in sample indices. If only one of the two can be measured, the other is taken as 50 minus the measured one.
- R8: `sym_val` = |(max − base) − (base − min)| × (1 + |T1 − T2|), saturated at 4095. The factor in parentheses is 1 when the frame lacks either kind of peak.
- R9: Samples presented while a frame is being analysed are ignored. The next frame starts with the first valid sample after `done`.
- R10: One full 10 kHz cycle per frame reads exactly 10000 (0x2710).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Unsigned ADC sample |
| freq_hz | output | 16 | Frequency estimate in Hz |
| max_val | output | 16 | Frame maximum |
| min_val | output | 16 | Frame minimum |
| sym_val | output | 12 | Saturated symmetry figure |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest condition to reach from the ports is a sample that arrives while the analysis is still running. It has to be dropped without shifting the start of the following frame. The stimulus sends a full frame and then immediately pushes a burst of junk samples into the analysis window. It then sends a second, different frame. The second result matches only if the junk was discarded. Timing fallback and saturation are reached with hand-shaped frames: a single-cycle sine where only T1 can be measured, a spike frame whose amplitude imbalance overflows 12 bits, and an alternating pattern with more peaks than 16 bits of hertz can hold.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_MEAN   = 2'd1,
    ST_SCAN   = 2'd2,
    ST_EMIT   = 2'd3
  } ssa_state_e;

  // floor(sum / d) via multiply by ceil(2^k / d), then shift
  function automatic longint unsigned frame_mean(longint unsigned sum,
                                                 longint unsigned recip,
                                                 int unsigned k);
    return (sum * recip) >> k;
  endfunction

  function automatic longint unsigned mag(longint signed v);
    return (v < 0) ? longint'(-v) : longint'(v);
  endfunction

  function automatic bit is_crest(longint unsigned prev, longint unsigned cur,
                                  longint unsigned nxt, longint unsigned base);
    return (cur >= prev) && (cur > nxt) && (cur > base);
  endfunction

  function automatic bit is_trough(longint unsigned prev, longint unsigned cur,
                                   longint unsigned nxt, longint unsigned base);
    return (cur <= prev) && (cur < nxt) && (cur < base);
  endfunction

  function automatic longint unsigned freq_of(longint unsigned crests, bit both_kinds,
                                              longint unsigned step_hz,
                                              longint unsigned cap);
    longint unsigned f;
    if (!both_kinds) return 0;
    f = crests * step_hz;
    return (f > cap) ? cap : f;
  endfunction

  function automatic longint unsigned sym_figure(longint unsigned maxv, longint unsigned minv,
                                                 longint unsigned base,
                                                 longint unsigned t1, longint unsigned t2,
                                                 bit use_time, longint unsigned cap);
    longint unsigned amp;
    longint unsigned tfac;
    longint unsigned prod;
    amp  = mag(longint'(maxv) + longint'(minv) - 2 * longint'(base));
    tfac = use_time ? 1 + mag(longint'(t1) - longint'(t2)) : 1;
    prod = amp * tfac;
    return (prod > cap) ? cap : prod;
  endfunction

endpackage

// File: rtl/ssa_frame_store.sv
module ssa_frame_store #(
  parameter int FRAME_LEN = 50,
  parameter int SAMPLE_W  = 16,
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int SUM_W    = SAMPLE_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [SAMPLE_W-1:0] rd_prev,
  output logic [SAMPLE_W-1:0] rd_cur,
  output logic [SAMPLE_W-1:0] rd_next,
  output logic [SUM_W-1:0]    sum_q,
  output logic [SAMPLE_W-1:0] hi_q,
  output logic [SAMPLE_W-1:0] lo_q,
  output logic [IDX_W-1:0]    fill_cnt,
  output logic                frame_full
);

  logic [SAMPLE_W-1:0] mem_q [FRAME_LEN];
  logic take;

  assign take       = accept && smp_valid;
  assign frame_full = take && (fill_cnt == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      sum_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (take) begin
      fill_cnt <= frame_full ? '0 : fill_cnt + 1'b1;
      if (fill_cnt == '0) begin
        sum_q <= SUM_W'(smp_data);
        hi_q  <= smp_data;
        lo_q  <= smp_data;
      end else begin
        sum_q <= sum_q + SUM_W'(smp_data);
        if (smp_data > hi_q) hi_q <= smp_data;
        if (smp_data < lo_q) lo_q <= smp_data;
      end
    end
  end

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (take && fill_cnt == IDX_W'(g)) mem_q[g] <= smp_data;
    end
  end

  assign rd_prev = mem_q[rd_idx - 1'b1];
  assign rd_cur  = mem_q[rd_idx];
  assign rd_next = mem_q[rd_idx + 1'b1];

endmodule

// File: rtl/ssa_peak_scan.sv
module ssa_peak_scan #(
  parameter int FRAME_LEN = 50,
  parameter int SAMPLE_W  = 16,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                step,
  input  logic [IDX_W-1:0]    idx,
  input  logic [SAMPLE_W-1:0] prev,
  input  logic [SAMPLE_W-1:0] cur,
  input  logic [SAMPLE_W-1:0] nxt,
  input  logic [SAMPLE_W-1:0] base,
  output logic                crest_hit,
  output logic                trough_hit,
  output logic [IDX_W-1:0]    crest_cnt,
  output logic [IDX_W-1:0]    trough_cnt,
  output logic [IDX_W-1:0]    t1_q,
  output logic [IDX_W-1:0]    t2_q,
  output logic                t1_ok,
  output logic                t2_ok
);

  logic [IDX_W-1:0] last_crest, last_trough;

  assign crest_hit  = step && ssa_pkg::is_crest(64'(prev), 64'(cur), 64'(nxt), 64'(base));
  assign trough_hit = step && ssa_pkg::is_trough(64'(prev), 64'(cur), 64'(nxt), 64'(base));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crest_cnt   <= '0;
      trough_cnt  <= '0;
      last_crest  <= '0;
      last_trough <= '0;
      t1_q        <= '0;
      t2_q        <= '0;
      t1_ok       <= 1'b0;
      t2_ok       <= 1'b0;
    end else begin
      if (crest_hit) begin
        crest_cnt  <= crest_cnt + 1'b1;
        last_crest <= idx;
        if (trough_cnt != '0 && !t2_ok) begin
          t2_q  <= idx - last_trough;
          t2_ok <= 1'b1;
        end
      end
      if (trough_hit) begin
        trough_cnt  <= trough_cnt + 1'b1;
        last_trough <= idx;
        if (crest_cnt != '0 && !t1_ok) begin
          t1_q  <= idx - last_crest;
          t1_ok <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sine_symmetry_analyzer.sv
module sine_symmetry_analyzer #(
  parameter int FRAME_LEN = 50,
  parameter int SAMPLE_W  = 16,
  parameter int FREQ_W    = 16,
  parameter int SYM_W     = 12,
  parameter int STEP_HZ   = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [FREQ_W-1:0]   freq_hz,
  output logic [SAMPLE_W-1:0] max_val,
  output logic [SAMPLE_W-1:0] min_val,
  output logic [SYM_W-1:0]    sym_val,
  output logic                done
);

  import ssa_pkg::*;

  localparam int IDX_W   = $clog2(FRAME_LEN);
  localparam int SUM_W   = SAMPLE_W + IDX_W;
  localparam int RECIP_K = SUM_W + IDX_W;
  localparam longint unsigned RECIP    = ((64'd1 << RECIP_K) + 64'(FRAME_LEN) - 1) / 64'(FRAME_LEN);
  localparam longint unsigned SYM_CAP  = (64'd1 << SYM_W) - 1;
  localparam longint unsigned FREQ_CAP = (64'd1 << FREQ_W) - 1;
  localparam logic [IDX_W-1:0] LAST_SCAN = IDX_W'(FRAME_LEN - 2);

  ssa_state_e state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SAMPLE_W-1:0] base_q;

  logic                accept, busy, frame_full;
  logic [SAMPLE_W-1:0] rd_prev, rd_cur, rd_next, hi_q, lo_q;
  logic [SUM_W-1:0]    sum_q;
  logic [IDX_W-1:0]    fill_cnt;

  logic                crest_hit, trough_hit, t1_ok, t2_ok;
  logic [IDX_W-1:0]    crest_cnt, trough_cnt, t1_q, t2_q;

  logic                both_kinds;
  longint unsigned     t1_eff, t2_eff;
  logic [FREQ_W-1:0]   freq_next;
  logic [SYM_W-1:0]    sym_next;
  logic [SAMPLE_W-1:0] base_next;

  assign accept = (state_q == ST_GATHER);
  assign busy   = !accept;

  ssa_frame_store #(.FRAME_LEN(FRAME_LEN), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_idx(idx_q), .rd_prev(rd_prev), .rd_cur(rd_cur), .rd_next(rd_next),
    .sum_q(sum_q), .hi_q(hi_q), .lo_q(lo_q),
    .fill_cnt(fill_cnt), .frame_full(frame_full)
  );

  ssa_peak_scan #(.FRAME_LEN(FRAME_LEN), .SAMPLE_W(SAMPLE_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == ST_MEAN), .step(state_q == ST_SCAN),
    .idx(idx_q), .prev(rd_prev), .cur(rd_cur), .nxt(rd_next), .base(base_q),
    .crest_hit(crest_hit), .trough_hit(trough_hit),
    .crest_cnt(crest_cnt), .trough_cnt(trough_cnt),
    .t1_q(t1_q), .t2_q(t2_q), .t1_ok(t1_ok), .t2_ok(t2_ok)
  );

  assign base_next  = SAMPLE_W'(frame_mean(64'(sum_q), RECIP, RECIP_K));
  assign both_kinds = (crest_cnt != '0) && (trough_cnt != '0);

  always_comb begin
    t1_eff = 64'(t1_q);
    t2_eff = 64'(t2_q);
    if (t1_ok && !t2_ok) t2_eff = 64'(FRAME_LEN) - 64'(t1_q);
    if (t2_ok && !t1_ok) t1_eff = 64'(FRAME_LEN) - 64'(t2_q);
  end

  assign freq_next = FREQ_W'(freq_of(64'(crest_cnt), both_kinds, 64'(STEP_HZ), FREQ_CAP));
  assign sym_next  = SYM_W'(sym_figure(64'(hi_q), 64'(lo_q), 64'(base_q),
                                       t1_eff, t2_eff, both_kinds, SYM_CAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      idx_q   <= '0;
      base_q  <= '0;
      freq_hz <= '0;
      max_val <= '0;
      min_val <= '0;
      sym_val <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_GATHER: if (frame_full) state_q <= ST_MEAN;
        ST_MEAN: begin
          base_q  <= base_next;
          idx_q   <= IDX_W'(1);
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (idx_q == LAST_SCAN) state_q <= ST_EMIT;
          else                    idx_q   <= idx_q + 1'b1;
        end
        ST_EMIT: begin
          freq_hz <= freq_next;
          sym_val <= sym_next;
          max_val <= hi_q;
          min_val <= lo_q;
          done    <= 1'b1;
          idx_q   <= '0;
          state_q <= ST_GATHER;
        end
        default: state_q <= ST_GATHER;
      endcase
    end
  end

endmodule

// File: rtl/sine_symmetry_analyzer_chk.sv
module sine_symmetry_analyzer_chk #(
  parameter int FRAME_LEN = 50,
  parameter int SAMPLE_W  = 16,
  parameter int FREQ_W    = 16,
  parameter int SYM_W     = 12,
  parameter int MAX_LAT   = 200,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic                busy,
  input logic                frame_full,
  input logic                crest_hit,
  input logic                trough_hit,
  input logic [IDX_W-1:0]    fill_cnt,
  input logic [IDX_W-1:0]    crest_cnt,
  input logic [IDX_W-1:0]    trough_cnt,
  input logic [FREQ_W-1:0]   freq_hz,
  input logic [SAMPLE_W-1:0] max_val,
  input logic [SAMPLE_W-1:0] min_val,
  input logic [SYM_W-1:0]    sym_val
);

  logic [15:0] lat_cnt;
  logic        lat_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_run <= 1'b0;
    end else if (frame_full) begin
      lat_cnt <= '0;
      lat_run <= 1'b1;
    end else if (done) begin
      lat_run <= 1'b0;
    end else if (lat_run) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R2: result strobe is a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: outputs hold between strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(freq_hz) && $stable(sym_val) && $stable(max_val) && $stable(min_val));

  // R2: analysis ends within the latency budget
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_run |-> lat_cnt < 16'(MAX_LAT));

  // R3: reported extremes are ordered
  p_extreme_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> max_val >= min_val);

  // R5: a sample cannot be both a crest and a trough
  p_single_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(crest_hit && trough_hit));

  // R6: missing peak kind forces zero frequency
  p_freq_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && (crest_cnt == '0 || trough_cnt == '0)) |-> freq_hz == '0);

  // R9: no sample is gathered while analysing
  p_drop_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fill_cnt == '0);

endmodule

bind sine_symmetry_analyzer sine_symmetry_analyzer_chk #(
  .FRAME_LEN(FRAME_LEN), .SAMPLE_W(SAMPLE_W), .FREQ_W(FREQ_W), .SYM_W(SYM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .frame_full(frame_full),
  .crest_hit(crest_hit), .trough_hit(trough_hit), .fill_cnt(fill_cnt),
  .crest_cnt(crest_cnt), .trough_cnt(trough_cnt),
  .freq_hz(freq_hz), .max_val(max_val), .min_val(min_val), .sym_val(sym_val)
);

// File: tb/sine_symmetry_analyzer_tb_top.sv
`timescale 1ns/1ps
module sine_symmetry_analyzer_tb_top;

  localparam int N = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [15:0] freq_hz, max_val, min_val;
  logic [11:0] sym_val;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_cyc = 0;
  bit finished = 0;
  int frame [N];
  int e_freq, e_max, e_min, e_sym;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sine_symmetry_analyzer dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .freq_hz(freq_hz), .max_val(max_val), .min_val(min_val),
    .sym_val(sym_val), .done(done)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  // Independent reference from the requirements (R3..R8)
  task automatic model();
    int sum = 0, base, np = 0, nn = 0, lp = 0, ln = 0;
    int t1 = 0, t2 = 0;
    bit ok1 = 0, ok2 = 0;
    e_max = frame[0]; e_min = frame[0];
    for (int i = 0; i < N; i++) begin
      sum += frame[i];
      if (frame[i] > e_max) e_max = frame[i];
      if (frame[i] < e_min) e_min = frame[i];
    end
    base = sum / N;
    for (int i = 1; i < N - 1; i++) begin
      bit up = frame[i] >= frame[i-1] && frame[i] > frame[i+1] && frame[i] > base;
      bit dn = frame[i] <= frame[i-1] && frame[i] < frame[i+1] && frame[i] < base;
      if (up) begin
        if (nn > 0 && !ok2) begin t2 = i - ln; ok2 = 1; end
        np++; lp = i;
      end
      if (dn) begin
        if (np > 0 && !ok1) begin t1 = i - lp; ok1 = 1; end
        nn++; ln = i;
      end
    end
    if (ok1 && !ok2) t2 = N - t1;
    if (ok2 && !ok1) t1 = N - t2;
    if (np > 0 && nn > 0) begin
      e_freq = np * 10000;
      if (e_freq > 65535) e_freq = 65535;
      e_sym = iabs((e_max - base) - (base - e_min)) * (1 + iabs(t1 - t2));
    end else begin
      e_freq = 0;
      e_sym = iabs((e_max - base) - (base - e_min));
    end
    if (e_sym > 4095) e_sym = 4095;
  endtask

  task automatic send_frame();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 16'(frame[i]);
    end
    last_cyc = cyc;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_and_compare(string tag);
    int guard = 0;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    check("R2", {tag, " done seen"}, int'(done), 1);
    check("R2", {tag, " latency<=200"}, int'((cyc - last_cyc) <= 200), 1);
    check("R3", {tag, " max"}, int'(max_val), e_max);
    check("R3", {tag, " min"}, int'(min_val), e_min);
    check("R6", {tag, " freq"}, int'(freq_hz), e_freq);
    check("R8", {tag, " sym"}, int'(sym_val), e_sym);
    @(negedge clk);
    check("R2", {tag, " done one cycle"}, int'(done), 0);
    repeat (4) @(negedge clk);
    check("R2", {tag, " hold freq"}, int'(freq_hz), e_freq);
    check("R2", {tag, " hold sym"}, int'(sym_val), e_sym);
  endtask

  task automatic fill_sine(real cycles, real amp, real off, real clip_hi);
    for (int i = 0; i < N; i++) begin
      real v = off + amp * $sin(2.0 * 3.14159265358979 * cycles * (real'(i) + 0.5) / real'(N));
      if (v > clip_hi) v = clip_hi;
      frame[i] = $rtoi(v);
    end
  endtask

  task automatic t_reset();
    check("R1", "reset freq", int'(freq_hz), 0);
    check("R1", "reset max", int'(max_val), 0);
    check("R1", "reset min", int'(min_val), 0);
    check("R1", "reset sym", int'(sym_val), 0);
    check("R1", "reset done", int'(done), 0);
  endtask

  task automatic t_one_cycle_sine();   // R10, R7 fallback
    fill_sine(1.0, 20000.0, 32768.0, 1.0e9);
    model();
    send_frame();
    wait_and_compare("sine1");
    check("R10", "10 kHz reads 0x2710", int'(freq_hz), 16'h2710);
  endtask

  task automatic t_three_cycle_sine();  // R5, R6
    fill_sine(3.0, 12000.0, 20000.0, 1.0e9);
    model();
    send_frame();
    wait_and_compare("sine3");
    check("R6", "three cycles", int'(freq_hz), 30000);
  endtask

  task automatic t_clipped();  // R4, R8
    fill_sine(2.0, 20000.0, 32768.0, 38000.0);
    model();
    send_frame();
    wait_and_compare("clipped");
  endtask

  task automatic t_flat();  // R5, R6: no peaks
    for (int i = 0; i < N; i++) frame[i] = 12345;
    model();
    send_frame();
    wait_and_compare("flat");
    check("R6", "flat frame freq zero", int'(freq_hz), 0);
    check("R8", "flat frame sym zero", int'(sym_val), 0);
  endtask

  task automatic t_spike();  // R8 saturation
    for (int i = 0; i < N; i++) frame[i] = 30000;
    frame[10] = 60000;
    frame[30] = 29000;
    model();
    send_frame();
    wait_and_compare("spike");
    check("R8", "saturates at 4095", int'(sym_val), 4095);
  endtask

  task automatic t_alternating();  // R6 saturation
    for (int i = 0; i < N; i++) frame[i] = (i % 2 == 0) ? 1000 : 60000;
    model();
    send_frame();
    wait_and_compare("alt");
    check("R6", "freq saturates", int'(freq_hz), 65535);
  endtask

  task automatic t_skewed();  // R7: unequal half cycles
    for (int i = 0; i < N; i++)
      frame[i] = (i < 10) ? 10000 + i * 4000 : 50000 - (i - 10) * 1000;
    model();
    send_frame();
    wait_and_compare("skew");
  endtask

  task automatic t_busy_drop();  // R9
    fill_sine(2.0, 15000.0, 30000.0, 1.0e9);
    model();
    send_frame();
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 16'hFFFF;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    wait_and_compare("busyA");
    fill_sine(1.0, 9000.0, 25000.0, 1.0e9);
    model();
    send_frame();
    wait_and_compare("busyB_R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_one_cycle_sine();
    t_three_cycle_sine();
    t_clipped();
    t_flat();
    t_spike();
    t_alternating();
    t_skewed();
    t_busy_drop();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule